// File: doc/BRIEF.md
# Streaming 3x3 Box-Sum Filter

This block smooths a raster-scanned grayscale pixel stream by producing, for every accepted pixel, the unscaled sum of the 3x3 neighbourhood whose bottom-right corner is that pixel. The work splits into two passes. A horizontal pass adds the newest pixel to the two pixels before it on the same line. A vertical pass adds that row-sum to the row-sums stored for the two previous lines at the same column.

Only horizontal partial sums are kept in the two line memories. Raw pixels are not stored. The division by nine is left to the consumer. A frame begins with a start marker on its first pixel, and each line ends with an end marker on its last pixel. The input valid strobe may drop at any point, and the filter then waits.

Each result leaves one cycle after its pixel is accepted. It carries the column and row of the newest pixel, so the window centre lies one column left and one row up. A window that would reach past the top or left edge of the frame is reported as not full, and its sum is forced to zero. Because the newest pixel always sits inside the frame, windows can never reach past the right or bottom edge.

Top module: `box3x3_sum`

## Requirements
- R1: While reset is held, and in the first cycle after it, out_valid and out_full are 0 and out_sum is 0.
- R2: Each pixel accepted with in_valid=1 produces exactly one cycle with out_valid=1, one clock later. That cycle's out_x and out_y give the accepted pixel's column and row.
- R3: When the accepted pixel has column x>=2 and row y>=2, out_full is 1. out_sum is then the sum of the nine pixels in rows y-2..y and columns x-2..x of the current frame.
- R4: When the accepted pixel has x<2 or y<2, out_full is 0 and out_sum is 0.
- R5: A window of nine maximum-value pixels gives 9*(2^PIX_W-1), which is 2295 for 8-bit pixels, with no overflow. out_sum is PIX_W+4 bits wide.
- R6: A cycle with in_valid=0 changes no stored state. The next cycle has out_valid=0 and an unchanged out_sum. Results after the gap equal those of the same pixels sent back-to-back.
- R7: A pixel with in_sof=1 is column 0, row 0, whatever came before. This holds even when it arrives in the middle of a line or frame, and the rows that follow are then not full until row 2.
- R8: After a pixel with in_eol=1, the next pixel without in_sof is column 0 of the next row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel accepted this cycle |
| in_pix | input | PIX_W | Pixel value |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Result present |
| out_full | output | 1 | Window lies wholly inside the frame |
| out_sum | output | PIX_W+4 | Sum of the nine window pixels |
| out_x | output | $clog2(LINE_W) | Column of the newest window pixel |
| out_y | output | $clog2(LINES) | Row of the newest window pixel |

## Verification
The bench builds the filter with a 6-pixel line and 5-line frames. At that size every column and row position, including all edge and interior windows, is swept frame after frame. The frames use ramp, saturated and pseudo-random pixel patterns. Expected sums are computed directly from the bench's stored copy of each frame. The small size also makes it cheap to insert idle gaps on every pixel and to abort a frame halfway through. This shows that stalls and restarts leave the stored line sums intact, or correctly superseded.

// File: rtl/box3x3_sum.sv
module box3x3_sum #(
  parameter int LINE_W = 640,
  parameter int LINES  = 480,
  parameter int PIX_W  = 8,
  localparam int XW    = $clog2(LINE_W),
  localparam int YW    = $clog2(LINES),
  localparam int SUM_W = PIX_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_sof,
  input  logic             in_eol,
  output logic             out_valid,
  output logic             out_full,
  output logic [SUM_W-1:0] out_sum,
  output logic [XW-1:0]    out_x,
  output logic [YW-1:0]    out_y
);
  localparam int HW = PIX_W + 2;
  localparam int MAX_SUM = 9 * ((1 << PIX_W) - 1);

  logic [XW-1:0]    x_cnt, cx;
  logic [YW-1:0]    y_cnt, cy;
  logic [PIX_W-1:0] p1, p2;
  logic [HW-1:0]    hsum, up1, up2;
  logic [SUM_W-1:0] vsum;
  logic             full;
  logic [HW-1:0]    row1 [LINE_W];
  logic [HW-1:0]    row2 [LINE_W];

  assign cx   = in_sof ? '0 : x_cnt;
  assign cy   = in_sof ? '0 : y_cnt;
  assign hsum = HW'(in_pix) + HW'(p1) + HW'(p2);
  assign up1  = row1[cx];
  assign up2  = row2[cx];
  assign vsum = SUM_W'(hsum) + SUM_W'(up1) + SUM_W'(up2);
  assign full = (cx >= XW'(2)) && (cy >= YW'(2));

  always_ff @(posedge clk)
    if (in_valid) begin
      row2[cx] <= up1;
      row1[cx] <= hsum;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_cnt <= '0; y_cnt <= '0; p1 <= '0; p2 <= '0;
      out_valid <= 1'b0; out_full <= 1'b0; out_sum <= '0;
      out_x <= '0; out_y <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        p1 <= in_pix;
        p2 <= p1;
        if (in_eol) begin
          x_cnt <= '0;
          y_cnt <= cy + YW'(1);
        end else begin
          x_cnt <= cx + XW'(1);
          y_cnt <= cy;
        end
        out_full <= full;
        out_sum  <= full ? vsum : '0;
        out_x    <= cx;
        out_y    <= cy;
      end
    end
  end

  AST_ONE_PER_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_FULL_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    out_full |-> (out_x >= XW'(2) && out_y >= YW'(2))); // R3
  AST_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_full) |-> out_sum == '0); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_sum <= SUM_W'(MAX_SUM)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sum))); // R6
  AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (out_x == '0 && out_y == '0)); // R7
endmodule

// File: tb/tb_box3x3_sum.sv
`timescale 1ns/1ps
module tb_box3x3_sum;
  localparam int W = 6, H = 5, PW = 8;
  logic clk = 0, rst_n = 0, in_valid = 0, in_sof = 0, in_eol = 0;
  logic [PW-1:0] in_pix = '0;
  logic out_valid, out_full;
  logic [11:0] out_sum;
  logic [2:0] out_x, out_y;
  int total = 0, bad = 0;
  int img [H][W];

  box3x3_sum #(.LINE_W(W), .LINES(H), .PIX_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_sof(in_sof), .in_eol(in_eol), .out_valid(out_valid),
    .out_full(out_full), .out_sum(out_sum), .out_x(out_x), .out_y(out_y));

  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int sum_before);
    @(negedge clk); in_valid = 0;
    @(posedge clk); #1;
    chk("R6 valid low", out_valid, 0);
    chk("R6 sum held", out_sum, sum_before);
  endtask

  task automatic send(int x, int y, bit sof, bit eol, int gap);
    int exp;
    @(negedge clk);
    in_valid = 1; in_pix = PW'(img[y][x]); in_sof = sof; in_eol = eol;
    @(posedge clk); #1;
    chk("R2 valid", out_valid, 1);
    chk("R2 x R8", out_x, x);
    chk("R2 y R7", out_y, y);
    exp = 0;
    if (x >= 2 && y >= 2)
      for (int r = y - 2; r <= y; r++)
        for (int c = x - 2; c <= x; c++) exp += img[r][c];
    chk((x >= 2 && y >= 2) ? "R3 full" : "R4 edge", out_full, (x >= 2 && y >= 2));
    chk((x >= 2 && y >= 2) ? "R3 sum R5" : "R4 zero", out_sum, exp);
    in_sof = 0; in_eol = 0;
    if (gap) idle(exp);
  endtask

  task automatic frame(int rows, int mode, int gaps);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        case (mode)
          0: img[y][x] = x * 10 + y * 3;
          1: img[y][x] = 255;
          default: img[y][x] = $urandom_range(0, 255);
        endcase
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < W; x++)
        send(x, y, (x == 0 && y == 0), (x == W - 1), gaps && ((x + y) % 2 == 0));
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk("R1 valid", out_valid, 0);
    chk("R1 full", out_full, 0);
    chk("R1 sum", out_sum, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 after", out_valid, 0);
    frame(H, 0, 0);
    frame(H, 1, 0);           // R5 saturated
    frame(H, 2, 1);           // R6 gaps
    frame(2, 2, 0);           // aborted frame
    frame(H, 2, 0);           // R7 restart
    for (int i = 0; i < 20; i++) frame(H, 2, i % 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule